// File: doc/BRIEF.md
# Interrupt Recognition and Entry Sequencer

This block is the interrupt front end of a small 8-bit processor core. It watches two active-low request lines. The first is non-maskable: its falling edge is captured in a latch, so even a pulse lasting a single clock is kept. The second is maskable: its low level is sampled and only counts while the core's interrupt-disable flag is clear. A request is not acted on at once. It waits until the core signals that the current instruction has finished.

When a request is accepted, the block takes over the memory bus for a fixed entry walk:

1. two internal cycles;
2. three pushes onto a descending stack in page 0x01: return address high byte, return address low byte, then the status byte with the break bit forced to 0;
3. two reads of the handler address, low byte first, from the vector of the winning source.

The return address is pushed exactly as it was presented; it is not advanced. When the walk ends, the block hands back the new program counter, the new stack pointer and the status byte with interrupt-disable set.

The winning source is decided at the first vector read, not at acceptance. A non-maskable edge that arrives during the pushes of a maskable entry therefore redirects that entry to the non-maskable handler. The non-maskable latch is cleared in the same cycle as that first vector read.

Top module: `irq_entry_seq`

## Requirements
- R1: A falling edge on `nmi_n` is latched even if the line is low for only one clock. It is taken at the next boundary whatever `iflag_in` is. A line that simply stays low yields only one entry.
- R2: `irq_n` is sampled through one register stage. It starts an entry only if the sampled level is low at a boundary and `iflag_in` is 0. A low pulse that is released before it is sampled at a boundary is lost, and a masked request causes no entry.
- R3: An entry starts only in the clock after a cycle with `insn_done` high, no entry in progress, and a request pending. Without a boundary a pending request waits indefinitely.
- R4: When both requests are pending at a boundary, the non-maskable request is taken first. The maskable request is taken at a later boundary if it is still present and unmasked.
- R5: The pushes write PC[15:8] to address 0x0100+SP, PC[7:0] to 0x0100+((SP-1) mod 256), then the status byte to 0x0100+((SP-2) mod 256). The returned `sp_out` equals (SP-3) mod 256, so the stack wraps inside page 0x01.
- R6: The pushed status is `flags_in` with bit 4 (break) cleared. The returned `flags_out` is `flags_in` with bit 2 (interrupt-disable) set. The pushed PC equals `pc_in` captured at acceptance, not advanced.
- R7: The handler address is read low byte first from 0xFFFA/0xFFFB for the non-maskable source, or from 0xFFFE/0xFFFF for the maskable one. `pc_out` = {high, low}.
- R8: `busy` is high for exactly 7 consecutive cycles per entry: 2 internal, 3 writes, 2 reads. `done` pulses for one cycle immediately after the last one.
- R9: The non-maskable latch clears in the first vector-read cycle. An edge latched before that cycle selects the non-maskable vector, even for a maskable entry. An edge arriving in that cycle or later stays pending for the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_n | input | 1 | Non-maskable request, active low, edge-detected |
| irq_n | input | 1 | Maskable request, active low, level-sampled |
| insn_done | input | 1 | High in the last cycle of an instruction |
| iflag_in | input | 1 | Interrupt-disable flag of the core |
| pc_in | input | 16 | Return address to push |
| flags_in | input | 8 | Status byte of the core |
| sp_in | input | 8 | Stack pointer of the core |
| mem_rdata | input | 8 | Read data, valid in the cycle the address is driven |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Bus write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| busy | output | 1 | Entry walk in progress; the core stalls |
| done | output | 1 | One-cycle pulse when the results are valid |
| pc_out | output | 16 | Handler address |
| flags_out | output | 8 | Status with interrupt-disable set |
| sp_out | output | 8 | Stack pointer after the three pushes |

## Verification
The hardest case to reach from the ports is a non-maskable edge landing in the middle of a maskable entry. Whether the vector is redirected or the request stays pending depends on which of the seven entry cycles the edge falls in.

The bench reaches this case by starting a maskable entry, counting cycles from the boundary, and injecting a one-clock pulse on `nmi_n` at a chosen cycle offset. It then checks the vector bytes read and whether a further entry follows at the next boundary.

A sweep over all 256 stack-pointer values, alternating the two sources, covers the page wrap and the break-bit and disable-bit handling.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_INT0,
      ST_INT1,
      ST_PUSH_HI,
      ST_PUSH_LO,
      ST_PUSH_P,
      ST_VEC_LO,
      ST_VEC_HI
   } entry_state_t;

   function automatic logic [7:0] bit_mask8(input int unsigned pos);
      logic [7:0] m;
      m = '0;
      m[pos[2:0]] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch #(
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_line,
   input  logic clr,
   output logic pending
);

   logic act;
   logic act_q;
   logic fall;
   logic pend_q;

   generate
      if (ACTIVE_LOW) begin : g_low
         assign act = ~req_line;
      end else begin : g_high
         assign act = req_line;
      end
   endgenerate

   assign fall = act & ~act_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         act_q  <= act;
         pend_q <= (pend_q & ~clr) | fall;
      end
   end

   assign pending = pend_q;

   // R1: a single-cycle assertion of the line is never lost
   assert_edge_latched_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !act_q) |=> pending);

   // R9: a clear with no new edge empties the latch
   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !(act && !act_q)) |=> !pending);

   // R1: a held level does not re-arm the latch
   assert_no_rearm_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!pending && act_q && act) |=> !pending);

endmodule

// File: rtl/irq_level_sampler.sv
module irq_level_sampler #(
   parameter int unsigned SYNC_STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_n,
   output logic level
);

   generate
      if (SYNC_STAGES > 4) begin : g_bad_stages
         $error("irq_level_sampler: SYNC_STAGES must be 0..4");
      end

      if (SYNC_STAGES == 0) begin : g_direct
         assign level = ~line_n;
      end else begin : g_chain
         logic [SYNC_STAGES:0] chain;
         assign chain[0] = ~line_n;
         for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
               if (!rst_n) chain[i+1] <= 1'b0;
               else        chain[i+1] <= chain[i];
            end
         end
         assign level = chain[SYNC_STAGES];

         // R2: the sampled level is the line delayed by the register chain
         assert_sample_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $past(chain[SYNC_STAGES-1]) == level);
      end
   endgenerate

endmodule

// File: rtl/entry_sequencer.sv
module entry_sequencer
   import irq_entry_pkg::*;
#(
   parameter int unsigned AW          = 16,
   parameter int unsigned DW          = 8,
   parameter logic [7:0]  STACK_PAGE  = 8'h01,
   parameter logic [15:0] NMI_VEC     = 16'hFFFA,
   parameter logic [15:0] IRQ_VEC     = 16'hFFFE,
   parameter int unsigned BREAK_BIT   = 4,
   parameter int unsigned DISABLE_BIT = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          start_nmi,
   input  logic          nmi_pend,
   input  logic [AW-1:0] pc_in,
   input  logic [DW-1:0] flags_in,
   input  logic [DW-1:0] sp_in,
   input  logic [DW-1:0] mem_rdata,
   output logic          nmi_clr,
   output logic          busy,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          mem_we,
   output logic          mem_re,
   output logic          done,
   output logic [AW-1:0] pc_out,
   output logic [DW-1:0] flags_out,
   output logic [DW-1:0] sp_out
);

   localparam logic [DW-1:0] BRK_MASK = DW'(bit_mask8(BREAK_BIT));
   localparam logic [DW-1:0] DIS_MASK = DW'(bit_mask8(DISABLE_BIT));
   localparam logic [AW-1:0] NMI_LO   = AW'(NMI_VEC);
   localparam logic [AW-1:0] NMI_HI   = AW'(NMI_VEC) + AW'(1);
   localparam logic [AW-1:0] IRQ_LO   = AW'(IRQ_VEC);
   localparam logic [AW-1:0] IRQ_HI   = AW'(IRQ_VEC) + AW'(1);

   generate
      if (AW != 2 * DW) begin : g_bad_aw
         $error("entry_sequencer: AW must be twice DW");
      end
      if (DW != 8) begin : g_bad_dw
         $error("entry_sequencer: DW must be 8");
      end
      if (BREAK_BIT >= DW || DISABLE_BIT >= DW || BREAK_BIT == DISABLE_BIT) begin : g_bad_bits
         $error("entry_sequencer: flag bit positions invalid");
      end
   endgenerate

   entry_state_t st, st_nx;
   logic [AW-1:0] pc_q;
   logic [DW-1:0] fl_q;
   logic [DW-1:0] sp_q;
   logic [DW-1:0] vlo_q;
   logic          src_nmi_q;
   logic          vsel_nmi_q;
   logic          vsel_nmi;
   logic          push_cyc;

   assign busy     = (st != ST_IDLE);
   assign push_cyc = (st == ST_PUSH_HI) || (st == ST_PUSH_LO) || (st == ST_PUSH_P);
   assign vsel_nmi = src_nmi_q | nmi_pend;
   assign nmi_clr  = (st == ST_VEC_LO) && nmi_pend;

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE:    if (start) st_nx = ST_INT0;
         ST_INT0:    st_nx = ST_INT1;
         ST_INT1:    st_nx = ST_PUSH_HI;
         ST_PUSH_HI: st_nx = ST_PUSH_LO;
         ST_PUSH_LO: st_nx = ST_PUSH_P;
         ST_PUSH_P:  st_nx = ST_VEC_LO;
         ST_VEC_LO:  st_nx = ST_VEC_HI;
         ST_VEC_HI:  st_nx = ST_IDLE;
         default:    st_nx = ST_IDLE;
      endcase
   end

   always_comb begin
      mem_addr  = '0;
      mem_wdata = '0;
      mem_we    = 1'b0;
      mem_re    = 1'b0;
      unique case (st)
         ST_PUSH_HI: begin
            mem_addr  = {STACK_PAGE, sp_q};
            mem_wdata = pc_q[AW-1:DW];
            mem_we    = 1'b1;
         end
         ST_PUSH_LO: begin
            mem_addr  = {STACK_PAGE, sp_q};
            mem_wdata = pc_q[DW-1:0];
            mem_we    = 1'b1;
         end
         ST_PUSH_P: begin
            mem_addr  = {STACK_PAGE, sp_q};
            mem_wdata = fl_q & ~BRK_MASK;
            mem_we    = 1'b1;
         end
         ST_VEC_LO: begin
            mem_addr = vsel_nmi ? NMI_LO : IRQ_LO;
            mem_re   = 1'b1;
         end
         ST_VEC_HI: begin
            mem_addr = vsel_nmi_q ? NMI_HI : IRQ_HI;
            mem_re   = 1'b1;
         end
         default: begin
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         pc_q       <= '0;
         fl_q       <= '0;
         sp_q       <= '0;
         vlo_q      <= '0;
         src_nmi_q  <= 1'b0;
         vsel_nmi_q <= 1'b0;
         done       <= 1'b0;
         pc_out     <= '0;
         flags_out  <= '0;
         sp_out     <= '0;
      end else begin
         st   <= st_nx;
         done <= (st == ST_VEC_HI);
         if (st == ST_IDLE && start) begin
            pc_q      <= pc_in;
            fl_q      <= flags_in;
            sp_q      <= sp_in;
            src_nmi_q <= start_nmi;
         end
         if (push_cyc) begin
            sp_q <= sp_q - DW'(1);
         end
         if (st == ST_VEC_LO) begin
            vlo_q      <= mem_rdata;
            vsel_nmi_q <= vsel_nmi;
         end
         if (st == ST_VEC_HI) begin
            pc_out    <= {mem_rdata, vlo_q};
            flags_out <= fl_q | DIS_MASK;
            sp_out    <= sp_q;
         end
      end
   end

   // R3: the walk begins only after an accepted start
   assert_start_on_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_INT0) |-> $past(start));

   // R5: consecutive pushes step down one byte within the stack page
   assert_stack_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |->
         (mem_addr[DW-1:0] == $past(mem_addr[DW-1:0]) - DW'(1)) &&
         (mem_addr[AW-1:DW] == STACK_PAGE));

   // R7: the high vector byte follows the low one at the next address
   assert_vec_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_VEC_HI) |-> mem_re && (mem_addr == $past(mem_addr) + AW'(1)));

   // R8: the done pulse follows the last vector read
   assert_done_after_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(st) == ST_VEC_HI) && !busy);

   // R9: a non-maskable entry still holds its latch when the fetch begins
   assert_src_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_VEC_LO && src_nmi_q) |-> nmi_pend);

   // R5: write and read strobes never overlap
   assert_bus_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
   parameter int unsigned IRQ_SYNC = 1,
   parameter logic [15:0] NMI_VEC  = 16'hFFFA,
   parameter logic [15:0] IRQ_VEC  = 16'hFFFE
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        nmi_n,
   input  logic        irq_n,
   input  logic        insn_done,
   input  logic        iflag_in,
   input  logic [15:0] pc_in,
   input  logic [7:0]  flags_in,
   input  logic [7:0]  sp_in,
   input  logic [7:0]  mem_rdata,
   output logic [15:0] mem_addr,
   output logic [7:0]  mem_wdata,
   output logic        mem_we,
   output logic        mem_re,
   output logic        busy,
   output logic        done,
   output logic [15:0] pc_out,
   output logic [7:0]  flags_out,
   output logic [7:0]  sp_out
);

   logic nmi_pend;
   logic nmi_clr;
   logic irq_lvl;
   logic take_irq;
   logic start;

   nmi_edge_latch #(.ACTIVE_LOW(1'b1)) u_nmi (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_line(nmi_n),
      .clr     (nmi_clr),
      .pending (nmi_pend)
   );

   irq_level_sampler #(.SYNC_STAGES(IRQ_SYNC)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .line_n(irq_n),
      .level (irq_lvl)
   );

   assign take_irq = irq_lvl & ~iflag_in;
   assign start    = insn_done & ~busy & (nmi_pend | take_irq);

   entry_sequencer #(
      .AW         (16),
      .DW         (8),
      .STACK_PAGE (8'h01),
      .NMI_VEC    (NMI_VEC),
      .IRQ_VEC    (IRQ_VEC),
      .BREAK_BIT  (4),
      .DISABLE_BIT(2)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .start_nmi (nmi_pend),
      .nmi_pend  (nmi_pend),
      .pc_in     (pc_in),
      .flags_in  (flags_in),
      .sp_in     (sp_in),
      .mem_rdata (mem_rdata),
      .nmi_clr   (nmi_clr),
      .busy      (busy),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .mem_re    (mem_re),
      .done      (done),
      .pc_out    (pc_out),
      .flags_out (flags_out),
      .sp_out    (sp_out)
   );

   // R2 R3: an entry begins only from a boundary with an admissible request
   assert_entry_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(insn_done) && ($past(nmi_pend) || ($past(irq_lvl) && !$past(iflag_in))));

   // R2: a masked request with no non-maskable one starts nothing
   assert_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && iflag_in && !nmi_pend) |=> !busy);

   // R9: the latch is cleared only by the first vector read
   assert_clear_point_R9: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_clr |-> mem_re && busy);

endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        nmi_n;
   logic        irq_n;
   logic        insn_done;
   logic        iflag_in;
   logic [15:0] pc_in;
   logic [7:0]  flags_in;
   logic [7:0]  sp_in;
   logic [7:0]  mem_rdata;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic        mem_we;
   logic        mem_re;
   logic        busy;
   logic        done;
   logic [15:0] pc_out;
   logic [7:0]  flags_out;
   logic [7:0]  sp_out;

   int errors = 0;
   int checks = 0;

   logic [15:0] w_addr [0:7];
   logic [7:0]  w_data [0:7];
   logic [15:0] r_addr [0:7];
   int nw = 0;
   int nr = 0;

   localparam logic [15:0] NMI_HANDLER = 16'h9234;
   localparam logic [15:0] IRQ_HANDLER = 16'h5EC7;

   always #10 clk = ~clk;

   irq_entry_seq u_irq_entry_seq (
      .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .irq_n(irq_n),
      .insn_done(insn_done), .iflag_in(iflag_in), .pc_in(pc_in),
      .flags_in(flags_in), .sp_in(sp_in), .mem_rdata(mem_rdata),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
      .mem_re(mem_re), .busy(busy), .done(done), .pc_out(pc_out),
      .flags_out(flags_out), .sp_out(sp_out)
   );

   always_comb begin
      case (mem_addr)
         16'hFFFA: mem_rdata = NMI_HANDLER[7:0];
         16'hFFFB: mem_rdata = NMI_HANDLER[15:8];
         16'hFFFE: mem_rdata = IRQ_HANDLER[7:0];
         16'hFFFF: mem_rdata = IRQ_HANDLER[15:8];
         default:  mem_rdata = mem_addr[7:0] ^ 8'h3C;
      endcase
   end

   always @(negedge clk) begin
      if (mem_we && nw < 8) begin
         w_addr[nw] = mem_addr;
         w_data[nw] = mem_wdata;
         nw = nw + 1;
      end
      if (mem_re && nr < 8) begin
         r_addr[nr] = mem_addr;
         nr = nr + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // kind: 0 boundary only, 1 non-maskable, 2 maskable, 3 both
   task automatic run_entry(input int kind, input bit ifl, input logic [15:0] pc,
                            input logic [7:0] fl, input logic [7:0] sp,
                            input int inj_at, input bit hold, input bit exp_nmi,
                            input string req);
      int busy_cnt;
      int done_at;
      logic [15:0] vec;
      logic [15:0] exp_pc;
      vec    = exp_nmi ? 16'hFFFA : 16'hFFFE;
      exp_pc = exp_nmi ? NMI_HANDLER : IRQ_HANDLER;
      @(negedge clk);
      pc_in = pc; flags_in = fl; sp_in = sp; iflag_in = ifl;
      if (kind == 1 || kind == 3) nmi_n = 1'b0;
      if (kind == 2 || kind == 3) irq_n = 1'b0;
      nw = 0; nr = 0;
      @(negedge clk);
      if (!hold) nmi_n = 1'b1;
      insn_done = 1'b1;
      busy_cnt = 0; done_at = -1;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         if (k == 0) begin
            insn_done = 1'b0;
            if (!hold) irq_n = 1'b1;
         end
         if (k == inj_at) nmi_n = 1'b0;
         if (k == inj_at + 1) nmi_n = 1'b1;
         if (busy) busy_cnt++;
         if (done && done_at < 0) done_at = k;
      end
      chk(busy_cnt == 7, "R8", "busy cycles", busy_cnt, 7);
      chk(done_at == 7, "R8", "done cycle", done_at, 7);
      chk(nw == 3, "R5", "write count", nw, 3);
      chk(w_addr[0] == {8'h01, sp}, "R5", "push hi addr", w_addr[0], {8'h01, sp});
      chk(w_addr[1] == {8'h01, sp - 8'd1}, "R5", "push lo addr", w_addr[1], {8'h01, sp - 8'd1});
      chk(w_addr[2] == {8'h01, sp - 8'd2}, "R5", "push p addr", w_addr[2], {8'h01, sp - 8'd2});
      chk(w_data[0] == pc[15:8], "R6", "pushed pc hi", w_data[0], pc[15:8]);
      chk(w_data[1] == pc[7:0], "R6", "pushed pc lo", w_data[1], pc[7:0]);
      chk(w_data[2] == (fl & 8'hEF), "R6", "pushed flags", w_data[2], fl & 8'hEF);
      chk(nr == 2, "R7", "read count", nr, 2);
      chk(r_addr[0] == vec && r_addr[1] == vec + 16'd1, req, "vector addrs",
          {r_addr[0], r_addr[1]}, {vec, vec + 16'd1});
      chk(pc_out == exp_pc, "R7", "handler pc", pc_out, exp_pc);
      chk(flags_out == (fl | 8'h04), "R6", "flags out", flags_out, fl | 8'h04);
      chk(sp_out == sp - 8'd3, "R5", "sp out", sp_out, sp - 8'd3);
   endtask

   // holds insn_done high for n cycles and expects no entry
   task automatic expect_idle(input int n, input string req, input string what);
      int seen;
      seen = 0;
      @(negedge clk);
      insn_done = 1'b1;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (busy) seen++;
      end
      insn_done = 1'b0;
      chk(seen == 0, req, what, seen, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; nmi_n = 1'b1; irq_n = 1'b1; insn_done = 1'b0; iflag_in = 1'b0;
      pc_in = '0; flags_in = '0; sp_in = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !mem_we && !mem_re, "R3", "reset idle",
          {busy, done, mem_we, mem_re}, 0);

      // R5 R6 R7: sweep every stack pointer, alternating sources
      for (int s = 0; s < 256; s++) begin
         logic [7:0] sb;
         sb = 8'(s);
         if (s[0])
            run_entry(1, 1'b1, {sb ^ 8'hA5, ~sb}, {sb[4:0], sb[7:5]}, sb, -1, 1'b0, 1'b1, "R7");
         else
            run_entry(2, 1'b0, {~sb, sb ^ 8'h5A}, sb ^ 8'h10, sb, -1, 1'b0, 1'b0, "R7");
      end

      // R2: masked maskable request starts nothing
      @(negedge clk); iflag_in = 1'b1; irq_n = 1'b0;
      expect_idle(6, "R2", "masked irq entry");
      irq_n = 1'b1; iflag_in = 1'b0;

      // R2: pulse released before a boundary is lost
      @(negedge clk); irq_n = 1'b0;
      @(negedge clk); irq_n = 1'b1;
      @(negedge clk);
      expect_idle(4, "R2", "lost irq pulse");

      // R1 R3: one-clock NMI pulse waits without a boundary
      @(negedge clk); nmi_n = 1'b0;
      @(negedge clk); nmi_n = 1'b1;
      begin
         int seen;
         seen = 0;
         for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (busy) seen++;
         end
         chk(seen == 0, "R3", "no entry without boundary", seen, 0);
      end
      run_entry(0, 1'b1, 16'hC3E1, 8'hFF, 8'hFD, -1, 1'b0, 1'b1, "R1");

      // R4: both pending -> NMI first, IRQ at the next boundary
      run_entry(3, 1'b0, 16'h1234, 8'h30, 8'h80, -1, 1'b1, 1'b1, "R4");
      nmi_n = 1'b1;
      run_entry(0, 1'b0, 16'h1234, 8'h30, 8'h7D, -1, 1'b1, 1'b0, "R4");
      irq_n = 1'b1;

      // R1: a line held low gives only one entry
      run_entry(1, 1'b0, 16'hABCD, 8'h00, 8'h40, -1, 1'b1, 1'b1, "R1");
      expect_idle(5, "R1", "held nmi re-entry");
      nmi_n = 1'b1;

      // R9: NMI edge during the pushes of an IRQ entry redirects the vector
      for (int inj = 0; inj <= 4; inj++) begin
         run_entry(2, 1'b0, 16'h4000 + 16'(inj), 8'h13, 8'h60, inj, 1'b0, 1'b1, "R9");
         expect_idle(3, "R9", "latch cleared by redirect");
      end

      // R9: NMI edge in the first fetch cycle stays pending
      run_entry(2, 1'b0, 16'h7777, 8'h01, 8'h20, 5, 1'b0, 1'b0, "R9");
      run_entry(0, 1'b1, 16'h8888, 8'h02, 8'h1D, -1, 1'b0, 1'b1, "R9");
      // R9: same during a non-maskable entry (new edge beats the clear)
      run_entry(1, 1'b1, 16'h9999, 8'h03, 8'h10, 5, 1'b0, 1'b1, "R9");
      run_entry(0, 1'b1, 16'h9999, 8'h03, 8'h0D, -1, 1'b0, 1'b1, "R9");
      expect_idle(3, "R9", "no third entry");

      // R3: insn_done held during an entry does not restart it
      @(negedge clk); irq_n = 1'b0; iflag_in = 1'b0;
      @(negedge clk); insn_done = 1'b1;
      begin
         int rises;
         logic prev;
         rises = 0; prev = 1'b0;
         for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (busy && !prev) rises++;
            prev = busy;
         end
         insn_done = 1'b0; irq_n = 1'b1;
         chk(rises == 1 && !busy, "R3", "single entry under held boundary",
             rises, 1);
      end
      repeat (4) @(negedge clk);

      finish_run();
   end

endmodule